// File: doc/BRIEF.md
# Global 64-bit Timer with Self-Rearming Comparator

This block is a global timer on a 32-bit register bus. It holds a 64-bit free-running counter and one 64-bit compare channel. The counter is read as two 32-bit halves. The two halves are never latched together. Instead, the upper half changes in the same cycle as the lower half wraps. Software can therefore read upper, then lower, then upper again, and retry if the two upper reads differ.

The compare channel raises a status bit when the counter equals the compare value while the channel is enabled. A level interrupt is driven from that status bit through an enable bit. In periodic use, the channel adds a programmable increment to its compare value on every match, so the interrupt repeats without software writing the compare value again.

Writes to the counter halves, the compare halves, the increment and the control register do not take effect at once. They travel through a fixed commit delay. On the cycle a write lands, a matching write-status bit sets. Software polls that bit and clears it by writing 1 to it.

Top module: `glb_cmp_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: A write to the delayed registers reaches its register on the 4th rising edge after the edge that sampled the write, and reads return the old value until then. The delayed registers are: counter low 0x100, counter high 0x104, compare low 0x200, compare high 0x204, increment 0x208 and control 0x240.
- R3: The commit edge of each delayed write sets its write-status bit.
  - Register 0x110 holds bit 0 for counter low and bit 1 for counter high.
  - Register 0x24C holds bit 0 for compare low, bit 1 for compare high, bit 2 for increment and bit 16 for control.
  - Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R4: Control register 0x240 has three bits. Bit 8 runs the counter, bit 0 enables the compare channel, and bit 1 enables auto-increment. These bits read back once committed.
- R5: While bit 8 is set, the 64-bit counter advances by one on each edge. While bit 8 is clear, it holds its value.
- R6: The upper half increments on exactly the edge where the lower half wraps from 0xFFFFFFFF to 0.
- R7: When the counter equals the 64-bit compare value and the channel is enabled, bit 0 of status register 0x244 sets on the next edge.
- R8: `irq` equals status bit 0 AND enable bit 0 of register 0x248. A write to 0x248 takes effect on its own edge.
- R9: Writing 1 to bit 0 of 0x244 clears the pending status on that edge. After the clear, `irq` stays low until the next match.
- R10: With auto-increment set, each match adds the 32-bit increment to the compare value on the same edge that sets the status bit.
- R11: Clearing the compare enable stops further matches and compare advances, but a status bit that is already pending stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W (12) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Level interrupt of compare channel 0 |

## Verification
Each result has a fixed due time, counted in edges from the edge that samples the write:
- A delayed register and its write-status bit change exactly 4 edges after that edge.
- The counter's first advance comes one edge after the control commit.
- The compare status and any compare advance come one edge after the cycle in which the counter equals the compare value.
- Writes to the interrupt enable and interrupt status registers act on their own edge.

The bench counts these edges from each write and samples 2 ns after the edge where a result is due. Around each commit, it reads both one edge early, expecting the old value, and on the due edge, expecting the new one. Where an exact count is not needed, as in the hold and disable checks, it compares two snapshots taken many edges apart.

// File: rtl/gtm_pkg.sv
package gtm_pkg;
   localparam int DW = 32;

   // Register offsets (byte addresses)
   localparam logic [11:0] OFS_CNT_LO  = 12'h100;
   localparam logic [11:0] OFS_CNT_HI  = 12'h104;
   localparam logic [11:0] OFS_CNT_WS  = 12'h110;
   localparam logic [11:0] OFS_CMP_LO  = 12'h200;
   localparam logic [11:0] OFS_CMP_HI  = 12'h204;
   localparam logic [11:0] OFS_INCR    = 12'h208;
   localparam logic [11:0] OFS_CTRL    = 12'h240;
   localparam logic [11:0] OFS_ISTAT   = 12'h244;
   localparam logic [11:0] OFS_IEN     = 12'h248;
   localparam logic [11:0] OFS_WS      = 12'h24C;

   // Control bit positions
   localparam int CTL_RUN  = 8;
   localparam int CTL_CEN  = 0;
   localparam int CTL_AUTO = 1;

   // Write-status bit position of the control register
   localparam int WS_CTRL  = 16;

   typedef enum logic [2:0] {
      TGT_NONE, TGT_CNT_LO, TGT_CNT_HI, TGT_CMP_LO, TGT_CMP_HI, TGT_INCR, TGT_CTRL
   } tgt_e;

   typedef struct packed {
      logic          vld;
      tgt_e          tgt;
      logic [DW-1:0] data;
   } wreq_t;
endpackage

// File: rtl/gtm_commit.sv
module gtm_commit
   import gtm_pkg::*;
#(
   parameter int LAT = 4
) (
   input  logic  clk,
   input  logic  rst_n,
   input  wreq_t req,
   output wreq_t late
);
   wreq_t stg [LAT];

   generate
      for (genvar gi = 0; gi < LAT; gi++) begin : g_stage
         if (gi == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[gi] <= '0;
               else        stg[gi] <= req;
            end
         end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[gi] <= '0;
               else        stg[gi] <= stg[gi-1];
            end
         end
      end
   endgenerate

   assign late = stg[LAT-1];
endmodule

// File: rtl/gtm_counter.sv
module gtm_counter #(
   parameter int HALF_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic                ld_lo,
   input  logic                ld_hi,
   input  logic [HALF_W-1:0]   ld_val,
   output logic [2*HALF_W-1:0] cnt
);
   localparam int FULL_W = 2 * HALF_W;

   logic [FULL_W-1:0] nxt;

   always_comb begin
      nxt = run ? cnt + FULL_W'(1) : cnt;
      if (ld_lo) nxt[HALF_W-1:0]      = ld_val;
      if (ld_hi) nxt[FULL_W-1:HALF_W] = ld_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= nxt;
   end

   // R5
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !ld_lo && !ld_hi) |=> cnt == $past(cnt) + FULL_W'(1));
   // R5
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !ld_lo && !ld_hi) |=> $stable(cnt));
   // R6
   cnt_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !ld_lo && !ld_hi && (&cnt[HALF_W-1:0]))
      |=> cnt[FULL_W-1:HALF_W] == $past(cnt[FULL_W-1:HALF_W]) + HALF_W'(1));
   // R6
   cnt_nocarry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_hi && !(&cnt[HALF_W-1:0])) |=> $stable(cnt[FULL_W-1:HALF_W]));
endmodule

// File: rtl/gtm_cmp.sv
module gtm_cmp #(
   parameter int HALF_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2*HALF_W-1:0] cnt,
   input  logic                en,
   input  logic                auto,
   input  logic                ld_lo,
   input  logic                ld_hi,
   input  logic                ld_inc,
   input  logic [HALF_W-1:0]   ld_val,
   input  logic                clr,
   output logic [2*HALF_W-1:0] cmp,
   output logic [HALF_W-1:0]   inc,
   output logic                hit,
   output logic                pend
);
   localparam int FULL_W = 2 * HALF_W;

   logic [FULL_W-1:0] cmp_nxt;

   assign hit = en && (cnt == cmp);

   always_comb begin
      cmp_nxt = (hit && auto) ? cmp + FULL_W'(inc) : cmp;
      if (ld_lo) cmp_nxt[HALF_W-1:0]      = ld_val;
      if (ld_hi) cmp_nxt[FULL_W-1:HALF_W] = ld_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp  <= '0;
         inc  <= '0;
         pend <= 1'b0;
      end else begin
         cmp  <= cmp_nxt;
         if (ld_inc) inc <= ld_val;
         pend <= hit | (pend & ~clr);
      end
   end

   // R7
   hit_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> pend);
   // R10
   auto_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && auto && !ld_lo && !ld_hi) |=> cmp == $past(cmp) + FULL_W'($past(inc)));
   // R11
   no_match_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !$rose(pend));
   // R11
   cmp_hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !ld_lo && !ld_hi) |=> $stable(cmp));
endmodule

// File: rtl/glb_cmp_timer.sv
module glb_cmp_timer
   import gtm_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int COMMIT_LAT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output logic              irq
);
   generate
      if (ADDR_W < 12) begin : g_bad_addr
         $error("ADDR_W must cover the 12-bit register map");
      end
      if (COMMIT_LAT < 1) begin : g_bad_lat
         $error("COMMIT_LAT must be at least 1");
      end
   endgenerate

   wreq_t req, late;
   tgt_e  wtgt;

   always_comb begin
      wtgt = TGT_NONE;
      unique case (bus_addr)
         ADDR_W'(OFS_CNT_LO): wtgt = TGT_CNT_LO;
         ADDR_W'(OFS_CNT_HI): wtgt = TGT_CNT_HI;
         ADDR_W'(OFS_CMP_LO): wtgt = TGT_CMP_LO;
         ADDR_W'(OFS_CMP_HI): wtgt = TGT_CMP_HI;
         ADDR_W'(OFS_INCR):   wtgt = TGT_INCR;
         ADDR_W'(OFS_CTRL):   wtgt = TGT_CTRL;
         default:             wtgt = TGT_NONE;
      endcase
      req.vld  = bus_wr && (wtgt != TGT_NONE);
      req.tgt  = wtgt;
      req.data = bus_wdata;
   end

   gtm_commit #(.LAT(COMMIT_LAT)) u_commit (
      .clk(clk), .rst_n(rst_n), .req(req), .late(late));

   logic cm_cnt_lo, cm_cnt_hi, cm_cmp_lo, cm_cmp_hi, cm_inc, cm_ctrl;
   assign cm_cnt_lo = late.vld && late.tgt == TGT_CNT_LO;
   assign cm_cnt_hi = late.vld && late.tgt == TGT_CNT_HI;
   assign cm_cmp_lo = late.vld && late.tgt == TGT_CMP_LO;
   assign cm_cmp_hi = late.vld && late.tgt == TGT_CMP_HI;
   assign cm_inc    = late.vld && late.tgt == TGT_INCR;
   assign cm_ctrl   = late.vld && late.tgt == TGT_CTRL;

   logic wr_cws, wr_ws, wr_istat, wr_ien;
   assign wr_cws   = bus_wr && bus_addr == ADDR_W'(OFS_CNT_WS);
   assign wr_ws    = bus_wr && bus_addr == ADDR_W'(OFS_WS);
   assign wr_istat = bus_wr && bus_addr == ADDR_W'(OFS_ISTAT);
   assign wr_ien   = bus_wr && bus_addr == ADDR_W'(OFS_IEN);

   logic       run_q, cen_q, auto_q, ien_q;
   logic [1:0] cws_q;
   logic [2:0] ws_q;
   logic       ws_ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q     <= 1'b0;
         cen_q     <= 1'b0;
         auto_q    <= 1'b0;
         ien_q     <= 1'b0;
         cws_q     <= '0;
         ws_q      <= '0;
         ws_ctrl_q <= 1'b0;
      end else begin
         if (cm_ctrl) begin
            run_q  <= late.data[CTL_RUN];
            cen_q  <= late.data[CTL_CEN];
            auto_q <= late.data[CTL_AUTO];
         end
         if (wr_ien) ien_q <= bus_wdata[0];
         cws_q <= {cm_cnt_hi, cm_cnt_lo}
                | (cws_q & ~({2{wr_cws}} & bus_wdata[1:0]));
         ws_q  <= {cm_inc, cm_cmp_hi, cm_cmp_lo}
                | (ws_q & ~({3{wr_ws}} & bus_wdata[2:0]));
         ws_ctrl_q <= cm_ctrl | (ws_ctrl_q & ~(wr_ws & bus_wdata[WS_CTRL]));
      end
   end

   logic [2*DW-1:0] cnt, cmp;
   logic [DW-1:0]   inc;
   logic            hit, pend;

   gtm_counter #(.HALF_W(DW)) u_counter (
      .clk(clk), .rst_n(rst_n), .run(run_q),
      .ld_lo(cm_cnt_lo), .ld_hi(cm_cnt_hi), .ld_val(late.data), .cnt(cnt));

   gtm_cmp #(.HALF_W(DW)) u_cmp (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .en(cen_q), .auto(auto_q),
      .ld_lo(cm_cmp_lo), .ld_hi(cm_cmp_hi), .ld_inc(cm_inc), .ld_val(late.data),
      .clr(wr_istat & bus_wdata[0]), .cmp(cmp), .inc(inc), .hit(hit), .pend(pend));

   assign irq = pend & ien_q;

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         ADDR_W'(OFS_CNT_LO): bus_rdata = cnt[DW-1:0];
         ADDR_W'(OFS_CNT_HI): bus_rdata = cnt[2*DW-1:DW];
         ADDR_W'(OFS_CNT_WS): bus_rdata = DW'(cws_q);
         ADDR_W'(OFS_CMP_LO): bus_rdata = cmp[DW-1:0];
         ADDR_W'(OFS_CMP_HI): bus_rdata = cmp[2*DW-1:DW];
         ADDR_W'(OFS_INCR):   bus_rdata = inc;
         ADDR_W'(OFS_CTRL):   begin
            bus_rdata[CTL_RUN]  = run_q;
            bus_rdata[CTL_CEN]  = cen_q;
            bus_rdata[CTL_AUTO] = auto_q;
         end
         ADDR_W'(OFS_ISTAT):  bus_rdata = DW'(pend);
         ADDR_W'(OFS_IEN):    bus_rdata = DW'(ien_q);
         ADDR_W'(OFS_WS):     begin
            bus_rdata[2:0]      = ws_q;
            bus_rdata[WS_CTRL]  = ws_ctrl_q;
         end
         default:             bus_rdata = '0;
      endcase
   end

   // R3
   ctrl_ws_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cm_ctrl |=> ws_ctrl_q);
   // R2
   cmp_lo_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cm_cmp_lo |=> cmp[DW-1:0] == $past(late.data));
   // R9
   istat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_istat && bus_wdata[0] && !hit) |=> !irq);
   // R8
   ien_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ien && !bus_wdata[0]) |=> !irq);
endmodule

// File: tb/test_glb_cmp_timer.sv
`timescale 1ns/1ps
module test_glb_cmp_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   glb_cmp_timer i_glb_cmp_timer (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bw(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1 bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      logic [11:0] offs [10] = '{12'h100, 12'h104, 12'h110, 12'h200, 12'h204,
                                 12'h208, 12'h240, 12'h244, 12'h248, 12'h24C};
      foreach (offs[i]) begin
         rd(offs[i], v);
         chk($sformatf("R1 reg %h after reset", offs[i]), v, 0);
      end
      chk("R1 irq after reset", irq, 0);
   endtask

   task automatic t_commit;
      logic [31:0] v;
      bw(12'h200, 32'h55);
      edges(3);
      rd(12'h200, v); chk("R2 compare low before commit", v, 0);
      rd(12'h24C, v); chk("R3 write-status before commit", v, 0);
      edges(1);
      rd(12'h200, v); chk("R2 compare low at commit", v, 32'h55);
      rd(12'h24C, v); chk("R3 write-status bit0 at commit", v, 1);
      bw(12'h24C, 32'h0);
      rd(12'h24C, v); chk("R3 writing 0 keeps status", v, 1);
      bw(12'h24C, 32'h1);
      rd(12'h24C, v); chk("R3 writing 1 clears status", v, 0);
   endtask

   task automatic t_counter;
      logic [31:0] hi, lo, v, ha, la;
      bw(12'h100, 32'hFFFF_FFFE);
      bw(12'h104, 32'h5);
      bw(12'h240, 32'h100);
      edges(4);
      rd(12'h240, v); chk("R4 control readback run bit", v, 32'h100);
      rd(12'h104, hi); rd(12'h100, lo);
      chk("R5 counter at control commit", {hi, lo}, 64'h5_FFFF_FFFE);
      edges(1);
      rd(12'h104, hi); rd(12'h100, lo);
      chk("R5 counter first step", {hi, lo}, 64'h5_FFFF_FFFF);
      edges(1);
      rd(12'h104, hi); rd(12'h100, lo);
      chk("R6 upper steps on low wrap", {hi, lo}, 64'h6_0000_0000);
      rd(12'h110, v); chk("R3 counter write-status bits", v, 3);
      rd(12'h24C, v); chk("R3 control write-status bit16", v, 32'h1_0000);
      bw(12'h110, 32'h3);
      bw(12'h24C, 32'h1_0000);
      bw(12'h240, 32'h0);
      edges(6);
      rd(12'h104, ha); rd(12'h100, la);
      edges(5);
      rd(12'h104, hi); rd(12'h100, lo);
      chk("R5 counter holds when stopped", {hi, lo}, {ha, la});
      rd(12'h110, v); chk("R3 counter write-status cleared", v, 0);
   endtask

   task automatic t_oneshot;
      logic [31:0] v;
      bw(12'h100, 32'h0);
      bw(12'h104, 32'h0);
      bw(12'h200, 32'd20);
      bw(12'h204, 32'h0);
      bw(12'h248, 32'h1);
      bw(12'h240, 32'h101);
      edges(24);
      chk("R7 no irq before match", irq, 0);
      rd(12'h244, v); chk("R7 status clear before match", v, 0);
      edges(1);
      rd(12'h244, v); chk("R7 status set after match", v, 1);
      chk("R8 irq with enable and status", irq, 1);
      bw(12'h248, 32'h0);
      #1 chk("R8 irq gated by enable", irq, 0);
      rd(12'h244, v); chk("R8 status kept while gated", v, 1);
      bw(12'h248, 32'h1);
      #1 chk("R8 irq back with enable", irq, 1);
      bw(12'h244, 32'h1);
      #1 chk("R9 irq low after clear", irq, 0);
      rd(12'h244, v); chk("R9 status cleared", v, 0);
      edges(30);
      chk("R9 irq stays low without new match", irq, 0);
   endtask

   task automatic t_auto;
      logic [31:0] v, x;
      bw(12'h240, 32'h0);
      edges(4);
      bw(12'h100, 32'h0);
      bw(12'h104, 32'h0);
      bw(12'h200, 32'd10);
      bw(12'h208, 32'd7);
      edges(4);
      bw(12'h244, 32'h1);
      bw(12'h240, 32'h103);
      edges(14);
      rd(12'h244, v); chk("R10 status before first match", v, 0);
      rd(12'h200, v); chk("R10 compare before first match", v, 10);
      edges(1);
      rd(12'h244, v); chk("R10 status at first match", v, 1);
      rd(12'h200, v); chk("R10 compare advanced once", v, 17);
      edges(7);
      rd(12'h200, v); chk("R10 compare advanced twice", v, 24);
      bw(12'h240, 32'h100);
      edges(5);
      rd(12'h200, x);
      edges(30);
      rd(12'h200, v); chk("R11 compare frozen when disabled", v, x);
      rd(12'h244, v); chk("R11 pending status retained", v, 1);
      rd(12'h240, v); chk("R4 control readback run only", v, 32'h100);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      edges(1);
      t_reset;
      t_commit;
      t_counter;
      t_oneshot;
      t_auto;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule